// File: doc/BRIEF.md
# Programmable Oscillator Reconfiguration Sequencer

This block retunes an external clock oscillator that is controlled over I2C. It picks one of eight preset output frequencies. Each preset is a fixed set of three fields: a 3-bit high-speed divider code, a 7-bit output divider code and a 28-bit DCO word. The DCO word equals the target frequency in MHz times the high-speed divider times the output divider times 64. When an enabled start pulse arrives, the block samples the mode input. It then issues nine single-register I2C writes in a fixed order. The first write freezes the DCO. The next six load the divider and frequency registers. The eighth releases the freeze, and the last tells the oscillator to take up the new settings.

The block has its own bit-level I2C master. SCL is push-pull. SDA is open-drain: the block only pulls it low and reads the wired line back. A missing acknowledge stops the sequence and raises the error output. A sequence that completes gives a one-cycle done pulse.

Top module: `osc_reprog_seq`

## Requirements
- R1: During and after reset, busy_o, done_o and err_o are 0, scl_o is 1 and sda_low_o is 0.
- R2: A sequence starts only on a cycle where start_i and enable_i are both 1. A start_i pulse with enable_i at 0 produces no bus activity and leaves busy_o at 0.
- R3: A sequence issues exactly nine writes, to registers 137, 7, 8, 9, 10, 11, 12, 137 and 135, in that order. Register 137 receives 0x10 (freeze) first and 0x00 (release) later. Register 135 receives 0x40.
- R4: The field bytes are packed as follows. Register 7 = {hs[2:0], n1[6:2]}. Register 8 = {n1[1:0], 6'b0}. Register 9 = {4'b0, dco[27:24]}. Registers 10, 11 and 12 = dco[23:16], dco[15:8] and dco[7:0].
- R5: The presets as (hs, n1, dco) are:
  - mode 0 (100 MHz) = (4, 10, 0x3E800)
  - mode 1 (125 MHz) = (4, 8, 0x3E800)
  - mode 2 (156.25 MHz) = (4, 8, 0x4E200)
  - mode 3 (250 MHz) = (4, 4, 0x3E800)
  - mode 4 (312.5 MHz) = (4, 4, 0x4E200)
  - mode 5 (322.265625 MHz) = (4, 4, 0x50910)
  - mode 6 (655.53 MHz) = (4, 2, 0x51F0F)
  - mode 7 (133.5 MHz) = (4, 10, 0x53700)
- R6: Each write is framed as START, then the device byte {DEV_ADDR, 0}, then the register byte, then the data byte, then STOP. Every byte is sent MSB first and is followed by one acknowledge bit, during which the block releases SDA.
- R7: Each SCL high phase inside a byte lasts 2*QTR clock cycles, where QTR = CLK_HZ/(4*SCL_HZ). SDA changes only while SCL is low, except for START and STOP.
- R8: If an acknowledge bit reads 1, the block ends that transfer with STOP and issues no further writes. err_o goes to 1, busy_o goes to 0 and done_o does not pulse. err_o returns to 0 once the next sequence is accepted.
- R9: After the final STOP, done_o is 1 for exactly one cycle. That is the cycle in which busy_o first reads 0.
- R10: While busy_o is 1, start_i is ignored. The mode is captured only when a sequence is accepted, so changes on mode_i during a sequence leave its writes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request pulse |
| enable_i | input | 1 | Qualifies start_i |
| mode_i | input | 3 | Preset frequency select |
| sda_i | input | 1 | Wired SDA line level |
| scl_o | output | 1 | I2C clock |
| sda_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when a sequence completes |
| err_o | output | 1 | An acknowledge was missing in the last sequence |

## Verification
Assertions check on every cycle that:
- SDA holds steady while SCL is high inside a byte.
- The byte engine is only started when it is idle.
- The write index stays in range.
- The captured mode does not move while a sequence runs.
- done is a single-cycle pulse that never coincides with an error.

Only the bench scenarios can show the rest. Its bus model decodes the writes and checks the register order, the byte packing for all eight presets and the SCL high-phase length. It also shows the abort after a missing acknowledge and that a start request is dropped when it is disabled or arrives while busy.

// File: rtl/osc_reprog_pkg.sv
// Package: shared types, register constants and preset table for the
// oscillator reconfiguration sequencer. Assumes the oscillator takes a
// 3-bit high-speed divider code, a 7-bit output divider code and a DCO word.
package osc_reprog_pkg;

    typedef struct packed {
        logic [2:0]  hs;
        logic [6:0]  n1;
        logic [27:0] dco;
    } osc_cfg_t;

    localparam int unsigned N_WRITES   = 9;
    localparam logic [7:0]  REG_FREEZE = 8'd137;
    localparam logic [7:0]  REG_APPLY  = 8'd135;
    localparam logic [7:0]  REG_FIELD0 = 8'd7;
    localparam logic [7:0]  VAL_FREEZE = 8'h10;
    localparam logic [7:0]  VAL_NEWF   = 8'h40;

    typedef enum logic [1:0] {E_IDLE, E_START, E_BIT, E_STOP} eng_st_t;
    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_st_t;

    // dco = f_MHz * hs * n1 * 64
    function automatic osc_cfg_t preset(input logic [2:0] m);
        osc_cfg_t c;
        case (m)
            3'd0:    c = '{hs: 3'd4, n1: 7'd10, dco: 28'h003E800}; // 100 MHz
            3'd1:    c = '{hs: 3'd4, n1: 7'd8,  dco: 28'h003E800}; // 125 MHz
            3'd2:    c = '{hs: 3'd4, n1: 7'd8,  dco: 28'h004E200}; // 156.25 MHz
            3'd3:    c = '{hs: 3'd4, n1: 7'd4,  dco: 28'h003E800}; // 250 MHz
            3'd4:    c = '{hs: 3'd4, n1: 7'd4,  dco: 28'h004E200}; // 312.5 MHz
            3'd5:    c = '{hs: 3'd4, n1: 7'd4,  dco: 28'h0050910}; // 322.265625 MHz
            3'd6:    c = '{hs: 3'd4, n1: 7'd2,  dco: 28'h0051F0F}; // 655.53 MHz
            default: c = '{hs: 3'd4, n1: 7'd10, dco: 28'h0053700}; // 133.5 MHz
        endcase
        return c;
    endfunction

endpackage

// File: rtl/osc_preset_rom.sv
// Preset lookup: maps the captured mode to divider and DCO fields (R5).
// Assumes the mode is held stable by the caller for a whole sequence.
module osc_preset_rom
    import osc_reprog_pkg::*;
(
    input  logic [2:0] mode_i,
    output osc_cfg_t   cfg_o
);

    // Purpose: combinational table decode
    always_comb begin
        cfg_o = preset(mode_i);
    end

endmodule

// File: rtl/osc_write_list.sv
// Write list: gives the register address and data byte for each step of
// the freeze / load / release / apply order (R3, R4).
// Assumes step_i stays below N_WRITES.
module osc_write_list
    import osc_reprog_pkg::*;
#(
    parameter int unsigned STEP_W = 4
)(
    input  logic [STEP_W-1:0] step_i,
    input  osc_cfg_t          cfg_i,
    output logic [7:0]        reg_o,
    output logic [7:0]        dat_o
);

    // Purpose: decode the step number into one register write
    always_comb begin
        case (step_i)
            STEP_W'(0): begin reg_o = REG_FREEZE;       dat_o = VAL_FREEZE; end
            STEP_W'(1): begin reg_o = REG_FIELD0;       dat_o = {cfg_i.hs, cfg_i.n1[6:2]}; end
            STEP_W'(2): begin reg_o = REG_FIELD0 + 8'd1; dat_o = {cfg_i.n1[1:0], 6'b0}; end
            STEP_W'(3): begin reg_o = REG_FIELD0 + 8'd2; dat_o = {4'b0, cfg_i.dco[27:24]}; end
            STEP_W'(4): begin reg_o = REG_FIELD0 + 8'd3; dat_o = cfg_i.dco[23:16]; end
            STEP_W'(5): begin reg_o = REG_FIELD0 + 8'd4; dat_o = cfg_i.dco[15:8]; end
            STEP_W'(6): begin reg_o = REG_FIELD0 + 8'd5; dat_o = cfg_i.dco[7:0]; end
            STEP_W'(7): begin reg_o = REG_FREEZE;       dat_o = 8'h00; end
            default:    begin reg_o = REG_APPLY;        dat_o = VAL_NEWF; end
        endcase
    end

endmodule

// File: rtl/i2c_wr_engine.sv
// I2C write engine: sends START, device byte, register byte, data byte and
// STOP. Each bit takes four quarter phases of QTR clocks. The engine stops
// early on a missing acknowledge (R6, R7, R8).
// Assumes go_i is pulsed only when the engine is idle and that the target
// never stretches SCL.
module i2c_wr_engine
    import osc_reprog_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 50_000_000,
    parameter int unsigned SCL_HZ   = 100_000,
    parameter logic [6:0]  DEV_ADDR = 7'h55
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_i,
    input  logic [7:0] reg_i,
    input  logic [7:0] dat_i,
    input  logic       sda_i,
    output logic       scl_o,
    output logic       sda_low_o,
    output logic       done_o,
    output logic       nack_o
);

    localparam int unsigned QTR     = (CLK_HZ / (4 * SCL_HZ) > 0) ? CLK_HZ / (4 * SCL_HZ) : 1;
    localparam int unsigned DIV_W   = (QTR > 1) ? $clog2(QTR) : 1;
    localparam int unsigned FRAME_W = 27;
    localparam logic [3:0]  ACK_SLOT = 4'd8;

    eng_st_t              st;
    logic [DIV_W-1:0]     div_q;
    logic                 tick;
    logic [1:0]           q;
    logic [FRAME_W-1:0]   frame_q;
    logic [3:0]           slot_q;
    logic [1:0]           byte_q;
    logic                 nack_q;
    logic                 done_q;
    logic                 scl_n, sdl_n, scl_q, sdl_q;

    assign tick = (div_q == DIV_W'(QTR - 1));

    // Purpose: quarter-phase divider, held at zero while idle
    always_ff @(posedge clk) begin
        if (!rst_n)              div_q <= '0;
        else if (st == E_IDLE)   div_q <= '0;
        else if (tick)           div_q <= '0;
        else                     div_q <= div_q + DIV_W'(1);
    end

    // Purpose: transfer state machine over START, 27 bit slots and STOP
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= E_IDLE;
            q       <= 2'd0;
            frame_q <= '0;
            slot_q  <= 4'd0;
            byte_q  <= 2'd0;
            nack_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                E_IDLE: begin
                    if (go_i) begin
                        frame_q <= {DEV_ADDR, 1'b0, 1'b1, reg_i, 1'b1, dat_i, 1'b1};
                        nack_q  <= 1'b0;
                        q       <= 2'd0;
                        slot_q  <= 4'd0;
                        byte_q  <= 2'd0;
                        st      <= E_START;
                    end
                end
                E_START: begin
                    if (tick) begin
                        q <= q + 2'd1;
                        if (q == 2'd3) st <= E_BIT;
                    end
                end
                E_BIT: begin
                    if (tick) begin
                        q <= q + 2'd1;
                        if (q == 2'd2 && slot_q == ACK_SLOT && sda_i) nack_q <= 1'b1;
                        if (q == 2'd3) begin
                            frame_q <= {frame_q[FRAME_W-2:0], 1'b1};
                            if (slot_q == ACK_SLOT) begin
                                slot_q <= 4'd0;
                                byte_q <= byte_q + 2'd1;
                                if (nack_q || byte_q == 2'd2) st <= E_STOP;
                            end else begin
                                slot_q <= slot_q + 4'd1;
                            end
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        q <= q + 2'd1;
                        if (q == 2'd3) begin
                            st     <= E_IDLE;
                            done_q <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // Purpose: decode the line levels from state and quarter phase
    always_comb begin
        case (st)
            E_IDLE:  begin scl_n = 1'b1;                  sdl_n = 1'b0; end
            E_START: begin scl_n = (q != 2'd3);           sdl_n = (q != 2'd0); end
            E_BIT:   begin scl_n = (q == 2'd1 || q == 2'd2);
                           sdl_n = (slot_q != ACK_SLOT) && !frame_q[FRAME_W-1]; end
            default: begin scl_n = (q != 2'd0);           sdl_n = (q < 2'd2); end
        endcase
    end

    // Purpose: register the bus outputs so they are glitch free
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sdl_q <= 1'b0;
        end else begin
            scl_q <= scl_n;
            sdl_q <= sdl_n;
        end
    end

    assign scl_o     = scl_q;
    assign sda_low_o = sdl_q;
    assign done_o    = done_q;
    assign nack_o    = nack_q;

    // R6: a transfer is only launched into an idle engine
    p_go_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> st == E_IDLE);

    // R7: data bits never move while SCL is high
    p_sda_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == E_BIT && $past(st) == E_BIT && scl_q && $past(scl_q)) |-> $stable(sdl_q));

endmodule

// File: rtl/osc_reprog_seq.sv
// Top: oscillator reconfiguration sequencer. Captures the mode on an
// enabled start, walks the nine-entry write list through the I2C engine
// and reports busy, done and error (R2, R3, R8, R9, R10).
// Assumes a single target device and an SDA line wired back into sda_i.
module osc_reprog_seq
    import osc_reprog_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 50_000_000,
    parameter int unsigned SCL_HZ   = 100_000,
    parameter logic [6:0]  DEV_ADDR = 7'h55
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       enable_i,
    input  logic [2:0] mode_i,
    input  logic       sda_i,
    output logic       scl_o,
    output logic       sda_low_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o
);

    localparam int unsigned STEP_W = $clog2(N_WRITES);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(N_WRITES - 1);

    seq_st_t           st;
    logic [STEP_W-1:0] step_q;
    logic [2:0]        mode_q;
    logic              done_q, err_q;
    osc_cfg_t          cfg;
    logic [7:0]        wr_reg, wr_dat;
    logic              eng_done, eng_nack;

    osc_preset_rom u_rom (
        .mode_i (mode_q),
        .cfg_o  (cfg)
    );

    osc_write_list #(.STEP_W(STEP_W)) u_list (
        .step_i (step_q),
        .cfg_i  (cfg),
        .reg_o  (wr_reg),
        .dat_o  (wr_dat)
    );

    i2c_wr_engine #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ), .DEV_ADDR(DEV_ADDR)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (st == S_ISSUE),
        .reg_i     (wr_reg),
        .dat_i     (wr_dat),
        .sda_i     (sda_i),
        .scl_o     (scl_o),
        .sda_low_o (sda_low_o),
        .done_o    (eng_done),
        .nack_o    (eng_nack)
    );

    // Purpose: sequence control, step counter, mode capture and status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            step_q <= '0;
            mode_q <= 3'd0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (start_i && enable_i) begin
                        mode_q <= mode_i;
                        step_q <= '0;
                        err_q  <= 1'b0;
                        st     <= S_ISSUE;
                    end
                end
                S_ISSUE: st <= S_WAIT;
                default: begin
                    if (eng_done) begin
                        if (eng_nack) begin
                            err_q <= 1'b1;
                            st    <= S_IDLE;
                        end else if (step_q == LAST) begin
                            done_q <= 1'b1;
                            st     <= S_IDLE;
                        end else begin
                            step_q <= step_q + STEP_W'(1);
                            st     <= S_ISSUE;
                        end
                    end
                end
            endcase
        end
    end

    assign busy_o = (st != S_IDLE);
    assign done_o = done_q;
    assign err_o  = err_q;

    // R9: done lasts a single cycle
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R3: done only follows the final write of the list
    p_done_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> step_q == LAST);

    // R3: the write index never leaves the list
    p_step_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step_q <= LAST);

    // R10: captured mode stays put while a sequence runs
    p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_IDLE && $past(st) != S_IDLE) |-> $stable(mode_q));

    // R8: a completed sequence never reports an error
    p_done_no_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_q && err_q));

endmodule

// File: tb/sim_osc_reprog_seq.sv
module sim_osc_reprog_seq;

    localparam int unsigned CLK_HZ = 50_000_000;
    localparam int unsigned SCL_HZ = 2_500_000;
    localparam int QTR = CLK_HZ / (4 * SCL_HZ);
    localparam logic [6:0] ADDR = 7'h55;

    // {mode[40:38], hs[37:35], n1[34:28], dco[27:0]}
    localparam logic [40:0] VEC [8] = '{
        {3'd3, 3'd4, 7'd4,  28'h003E800},
        {3'd0, 3'd4, 7'd10, 28'h003E800},
        {3'd7, 3'd4, 7'd10, 28'h0053700},
        {3'd5, 3'd4, 7'd4,  28'h0050910},
        {3'd1, 3'd4, 7'd8,  28'h003E800},
        {3'd6, 3'd4, 7'd2,  28'h0051F0F},
        {3'd4, 3'd4, 7'd4,  28'h004E200},
        {3'd2, 3'd4, 7'd8,  28'h004E200}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, enable_i = 1'b0;
    logic [2:0] mode_i = 3'd0;
    logic scl, sda_low, busy, done, err;
    logic slave_low;
    wire  sda_line = !(sda_low || slave_low);

    int total = 0, bad = 0;
    int nack_at = -1;

    always #2 clk = ~clk;

    osc_reprog_seq #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ), .DEV_ADDR(ADDR)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .enable_i(enable_i),
        .mode_i(mode_i), .sda_i(sda_line), .scl_o(scl), .sda_low_o(sda_low),
        .busy_o(busy), .done_o(done), .err_o(err)
    );

    // bus model: decodes writes, acknowledges bytes, times SCL high phases
    logic scl_p, sda_p, seen_rise;
    int bitcnt, nb, hi_cnt, mon_bytes, nw, hi_bad, addr_bad;
    logic [7:0] sh;
    logic [7:0] bt [3];
    logic [7:0] wreg [256];
    logic [7:0] wdat [256];

    always @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1; sda_p <= 1'b1; seen_rise <= 1'b0; slave_low <= 1'b0;
            bitcnt <= 0; nb <= 0; hi_cnt <= 0; mon_bytes <= 0; nw <= 0;
            hi_bad <= 0; addr_bad <= 0; sh <= 8'd0;
        end else begin
            scl_p <= scl;
            sda_p <= sda_line;
            if (scl) hi_cnt <= hi_cnt + 1;
            if (scl && scl_p && sda_p && !sda_line) begin
                bitcnt <= 0; nb <= 0; seen_rise <= 1'b0;
            end else if (scl && scl_p && !sda_p && sda_line) begin
                if (nb == 3) begin
                    wreg[nw[7:0]] <= bt[1];
                    wdat[nw[7:0]] <= bt[2];
                    if (bt[0] != {ADDR, 1'b0}) addr_bad <= addr_bad + 1;
                    nw <= nw + 1;
                end
                nb <= 0;
            end else if (scl && !scl_p) begin
                hi_cnt <= 1;
                seen_rise <= 1'b1;
                if (bitcnt < 8) begin
                    sh <= {sh[6:0], sda_line};
                    bitcnt <= bitcnt + 1;
                    if (bitcnt == 7) begin
                        if (nb < 3) bt[nb] <= {sh[6:0], sda_line};
                        nb <= nb + 1;
                        mon_bytes <= mon_bytes + 1;
                    end
                end else begin
                    bitcnt <= 0;
                end
            end else if (!scl && scl_p) begin
                if (seen_rise && hi_cnt != 2 * QTR) hi_bad <= hi_bad + 1;
                if (bitcnt == 8) slave_low <= (mon_bytes - 1 != nack_at);
                else             slave_low <= 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_wr(input int k, input logic [40:0] v);
        logic [2:0] hs = v[37:35];
        logic [6:0] n1 = v[34:28];
        logic [27:0] d = v[27:0];
        case (k)
            0: return {8'd137, 8'h10};
            1: return {8'd7,  hs, n1[6:2]};
            2: return {8'd8,  n1[1:0], 6'b0};
            3: return {8'd9,  4'b0, d[27:24]};
            4: return {8'd10, d[23:16]};
            5: return {8'd11, d[15:8]};
            6: return {8'd12, d[7:0]};
            7: return {8'd137, 8'h00};
            default: return {8'd135, 8'h40};
        endcase
    endfunction

    // one sequence; optional second start with another mode while busy
    task automatic run_seq(input logic [2:0] m, input bit disturb, input logic [2:0] m2,
                           output int dcnt, output logic busy_at_done, output logic got_err);
        dcnt = 0; busy_at_done = 1'b0; got_err = 1'b0;
        @(negedge clk); mode_i = m; enable_i = 1'b1; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            if (disturb && c == 300) begin mode_i = m2; start_i = 1'b1; end
            if (disturb && c == 301) start_i = 1'b0;
            if (done) begin dcnt++; busy_at_done = busy; end
            if (err) got_err = 1'b1;
            if (!busy) break;
        end
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            if (done) dcnt++;
        end
    endtask

    task automatic check_writes(input logic [40:0] v, input int base, input string tag);
        chk(nw - base == 9, {tag, " R3 write count"}, nw - base, 9);
        for (int k = 0; k < 9; k++)
            chk({wreg[8'(base + k)], wdat[8'(base + k)]} == exp_wr(k, v),
                {tag, " R3/R4/R5 reg+data"}, {wreg[8'(base + k)], wdat[8'(base + k)]}, exp_wr(k, v));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int dcnt, base, b0;
        logic bz, ge;
        repeat (4) @(negedge clk);
        chk(busy == 0 && done == 0 && err == 0, "R1 status in reset", {busy, done, err}, 0);
        chk(scl == 1 && sda_low == 0, "R1 bus in reset", {scl, sda_low}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && err == 0, "R1 status after reset", {busy, done, err}, 0);
        chk(scl == 1 && sda_low == 0, "R1 bus after reset", {scl, sda_low}, 2'b10);

        // R2: start without enable is dropped
        b0 = mon_bytes; bz = 1'b0;
        mode_i = 3'd2; enable_i = 1'b0; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        for (int c = 0; c < 60; c++) begin @(negedge clk); if (busy) bz = 1'b1; end
        chk(bz == 0, "R2 disabled start busy", bz, 0);
        chk(mon_bytes == b0 && scl == 1, "R2 disabled start bus idle", mon_bytes - b0, 0);

        // table walk over every preset
        foreach (VEC[i]) begin
            base = nw;
            b0 = addr_bad;
            run_seq(VEC[i][40:38], 1'b0, 3'd0, dcnt, bz, ge);
            check_writes(VEC[i], base, $sformatf("mode%0d", VEC[i][40:38]));
            chk(addr_bad == b0, "R6 device byte", addr_bad - b0, 0);
            chk(dcnt == 1, "R9 done pulse width", dcnt, 1);
            chk(bz == 0, "R9 busy low at done", bz, 0);
            chk(ge == 0, "R8 no error when acked", ge, 0);
        end
        chk(hi_bad == 0, "R7 SCL high phase length", hi_bad, 0);

        // R10: start with another mode while busy is ignored
        base = nw;
        run_seq(3'd6, 1'b1, 3'd1, dcnt, bz, ge);
        check_writes(VEC[5], base, "R10 busy restart");
        chk(dcnt == 1, "R10 single done", dcnt, 1);

        // R8: missing acknowledge on the register byte of the third write
        base = nw;
        nack_at = mon_bytes + 7;
        run_seq(3'd4, 1'b0, 3'd0, dcnt, bz, ge);
        chk(ge == 1 && err == 1, "R8 error raised", err, 1);
        chk(dcnt == 0, "R8 no done", dcnt, 0);
        chk(nw - base == 2, "R8 writes before abort", nw - base, 2);
        repeat (2000) @(negedge clk);
        chk(nw - base == 2 && busy == 0, "R8 no writes after abort", nw - base, 2);
        nack_at = -1;
        base = nw;
        @(negedge clk); mode_i = 3'd4; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        @(negedge clk);
        chk(err == 0, "R8 error cleared by new start", err, 0);
        dcnt = 0;
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            if (done) dcnt++;
            if (!busy) break;
        end
        check_writes(VEC[6], base, "R8 recovery");
        chk(dcnt == 1, "R9 done after recovery", dcnt, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule